// File: doc/BRIEF.md
# Modulo Address Correction Unit

This unit sits beside an address generator and keeps a pointer confined to a circular buffer. Each request carries a 16-bit byte pointer, a signed two's-complement modifier, an addressing mode and the buffer's first and last byte addresses. The unit forms the stepped address. If the step has left the buffer, it folds the address back by one buffer length. It then reports the effective address for the memory access, the value to store back into the pointer register and a strobe that says whether that store happens.

The sign of the modifier sets the direction. A modifier of zero or more is an incrementing step, checked against the last address. A negative modifier is a decrementing step, checked against the first address. Correction can be turned off in two ways. The `mod_en` input turns it off completely. A higher-priority bit-reversed scheme turns it off only for write accesses, and reads are still corrected. Results appear one clock after the request.

The unit assumes `buf_start <= buf_end`. It also assumes the modifier's magnitude is no larger than the buffer length. Under those conditions a single correction always brings the address back inside the buffer.

Top module: `modaddr_unit`

## Requirements
- R1: On an incrementing step (modifier bit 15 clear), a stepped address strictly greater than `buf_end` is reduced by the length (`buf_end - buf_start + 1`). A stepped address equal to `buf_end` is left as is.
- R2: On a decrementing step (modifier bit 15 set), a stepped address strictly less than `buf_start` is increased by the length. A stepped address equal to `buf_start` is left as is.
- R3: A step that passes a boundary by more than one word, with a modifier magnitude up to the buffer length, still lands at the correctly wrapped address inside the buffer.
- R4: Pre-modify mode (`addr_mode` = 0) drives `ea_out` and `wb_data` to the corrected stepped address and raises `wb_en`.
- R5: Post-modify mode (`addr_mode` = 1) drives `ea_out` to the unmodified pointer. It drives `wb_data` to the corrected stepped address and raises `wb_en`.
- R6: Offset mode (`addr_mode` = 2, and also the spare code 3) drives `ea_out` to the corrected stepped address and keeps `wb_en` low, so the pointer register is not changed.
- R7: With `bitrev_wr_active` high, a write request (`is_write` = 1) receives no correction. A read request is still corrected.
- R8: With `mod_en` low, the stepped address passes through uncorrected, and the modify modes still raise `wb_en`.
- R9: Outputs are registered with one cycle of latency. After reset, and in any cycle that follows a cycle with no request, `out_valid` and `wb_en` are low. Reset also clears `ea_out` and `wb_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| ptr_in | input | 16 | Current pointer register value (byte address) |
| modifier | input | 16 | Signed two's-complement step |
| addr_mode | input | 2 | 0 pre-modify, 1 post-modify, 2 offset, 3 treated as offset |
| buf_start | input | 16 | First byte address of the buffer |
| buf_end | input | 16 | Last byte address of the buffer |
| mod_en | input | 1 | Enables modulo correction |
| bitrev_wr_active | input | 1 | Bit-reversed addressing owns the write path |
| is_write | input | 1 | Request is a data write |
| out_valid | output | 1 | Result registers hold a new result |
| ea_out | output | 16 | Effective address for the access |
| wb_data | output | 16 | Value to store back into the pointer register |
| wb_en | output | 1 | Pointer write-back strobe |

## Verification
The bench puts stepped addresses that land exactly on each boundary and one word past it. A design that tests for equality, or uses the wrong strict/non-strict comparison, either wraps too early or lets the pointer escape the buffer. Overshooting steps in both directions catch a design that only handles a single-word crossing. Such a design would leave the address outside the buffer or fold it to the boundary itself. Post-modify and offset requests catch a swapped access address or a stray write-back strobe. Write and read requests under bit-reversed priority, and requests with correction turned off, catch a disable that is applied to the wrong path or that also suppresses the write-back.

// File: rtl/modaddr_pkg.sv
// Package: shared types for the modulo address correction unit.
// Assumes: two-bit addressing mode code supplied by the instruction decode.
package modaddr_pkg;

    typedef enum logic [1:0] {
        MODE_PRE    = 2'd0,
        MODE_POST   = 2'd1,
        MODE_OFFSET = 2'd2,
        MODE_SPARE  = 2'd3
    } addr_mode_e;

endpackage

// File: rtl/modaddr_step.sv
// Module: modaddr_step
// Forms the raw stepped address (pointer plus signed modifier, modulo 2^AW)
// and reports the step direction taken from the modifier sign bit.
// Assumes: modifier is two's complement of width AW.
module modaddr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] sum,
    output logic          going_down
);

    // Purpose: add the modifier and expose its sign as the direction.
    always_comb begin
        sum        = ptr + step;
        going_down = step[AW-1];
    end

endmodule

// File: rtl/modaddr_wrap.sv
// Module: modaddr_wrap
// Folds a stepped address back into [lo, hi] by one buffer length.
// Uses strict comparisons so overshooting steps are still caught.
// Assumes: lo <= hi and the step magnitude does not exceed hi - lo + 1.
module modaddr_wrap #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] raw,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          going_down,
    input  logic          active,
    output logic [AW-1:0] fixed
);

    logic [AW-1:0] span;
    logic          past_top;
    logic          past_bottom;

    // Purpose: compute the buffer length and the two strict boundary tests.
    always_comb begin
        span        = hi - lo + {{(AW-1){1'b0}}, 1'b1};
        past_top    = !going_down && (raw > hi);
        past_bottom =  going_down && (raw < lo);
    end

    // Purpose: pick the corrected address when correction is active.
    always_comb begin
        fixed = raw;
        if (active && past_top)
            fixed = raw - span;
        else if (active && past_bottom)
            fixed = raw + span;
    end

endmodule

// File: rtl/modaddr_ctrl.sv
// Module: modaddr_ctrl
// Decodes the addressing mode and the priority inputs into control flags:
// whether correction applies, whether the access uses the bare pointer,
// and whether the pointer register is written back.
// Assumes: the spare mode code behaves as offset mode.
module modaddr_ctrl
    import modaddr_pkg::*;
(
    input  logic       req,
    input  logic [1:0] mode_code,
    input  logic       enable,
    input  logic       brev_owns_write,
    input  logic       write_access,
    output logic       correct_on,
    output logic       access_bare_ptr,
    output logic       store_back
);

    addr_mode_e mode;

    // Purpose: derive the control flags from mode and priority inputs.
    always_comb begin
        mode            = addr_mode_e'(mode_code);
        correct_on      = enable && !(brev_owns_write && write_access);
        access_bare_ptr = (mode == MODE_POST);
        store_back      = req && ((mode == MODE_PRE) || (mode == MODE_POST));
    end

endmodule

// File: rtl/modaddr_unit.sv
// Module: modaddr_unit (top)
// Circular-buffer address correction with registered outputs.
// Results appear one clock after a request. Reset is synchronous, active low.
// Assumes: buf_start <= buf_end; |modifier| <= buffer length.
module modaddr_unit
    import modaddr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] ptr_in,
    input  logic [AW-1:0] modifier,
    input  logic [1:0]    addr_mode,
    input  logic [AW-1:0] buf_start,
    input  logic [AW-1:0] buf_end,
    input  logic          mod_en,
    input  logic          bitrev_wr_active,
    input  logic          is_write,
    output logic          out_valid,
    output logic [AW-1:0] ea_out,
    output logic [AW-1:0] wb_data,
    output logic          wb_en
);

    localparam logic [AW:0] ADDR_SPACE = {1'b1, {AW{1'b0}}};

    logic [AW-1:0] stepped;
    logic          dir_down;
    logic [AW-1:0] corrected;
    logic          corr_on;
    logic          use_ptr;
    logic          strobe_next;
    logic [AW-1:0] ea_next;

    modaddr_step #(.AW(AW)) u_step (
        .ptr        (ptr_in),
        .step       (modifier),
        .sum        (stepped),
        .going_down (dir_down)
    );

    modaddr_ctrl u_ctrl (
        .req             (in_valid),
        .mode_code       (addr_mode),
        .enable          (mod_en),
        .brev_owns_write (bitrev_wr_active),
        .write_access    (is_write),
        .correct_on      (corr_on),
        .access_bare_ptr (use_ptr),
        .store_back      (strobe_next)
    );

    modaddr_wrap #(.AW(AW)) u_wrap (
        .raw        (stepped),
        .lo         (buf_start),
        .hi         (buf_end),
        .going_down (dir_down),
        .active     (corr_on),
        .fixed      (corrected)
    );

    // Purpose: choose the access address (bare pointer in post-modify mode).
    always_comb begin
        ea_next = use_ptr ? ptr_in : corrected;
    end

    // Purpose: register the results; synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            ea_out    <= '0;
            wb_data   <= '0;
        end else begin
            out_valid <= in_valid;
            wb_en     <= strobe_next;
            if (in_valid) begin
                ea_out  <= ea_next;
                wb_data <= corrected;
            end
        end
    end

    // ---------------- assertions ----------------
    logic [AW-1:0] chk_len;
    logic [AW-1:0] chk_mag;
    logic          chk_safe;

    // Purpose: checker-side conditions under which a wrapped result must land inside the buffer.
    always_comb begin
        chk_len  = buf_end - buf_start + {{(AW-1){1'b0}}, 1'b1};
        chk_mag  = modifier[AW-1] ? (~modifier + {{(AW-1){1'b0}}, 1'b1}) : modifier;
        chk_safe = (buf_start <= buf_end) && (ptr_in >= buf_start) && (ptr_in <= buf_end)
                && (chk_mag <= chk_len) && (buf_start >= chk_len)
                && (({1'b0, buf_end} + {1'b0, chk_len}) < ADDR_SPACE);
    end

    // R3: a bounded step from inside the buffer stays inside the buffer.
    assert_stays_in_buffer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mod_en && !bitrev_wr_active && addr_mode == 2'd0 && chk_safe)
        |=> (ea_out >= $past(buf_start) && ea_out <= $past(buf_end)));

    // R5: post-modify accesses the unmodified pointer.
    assert_post_uses_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && addr_mode == 2'd1) |=> (ea_out == $past(ptr_in)));

    // R6: offset mode never strobes a write-back.
    assert_offset_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && addr_mode[1]) |=> !wb_en);

    // R8: correction off passes the stepped address through in pre-modify mode, and write-back still occurs.
    assert_bypass_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mod_en && addr_mode == 2'd0)
        |=> (ea_out == $past(ptr_in + modifier) && wb_en));

    // R9: no request means no result and no write-back.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wb_en));

endmodule

// File: tb/test_modaddr_unit.sv
module test_modaddr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] ptr_in = '0;
    logic [15:0] modifier = '0;
    logic [1:0]  addr_mode = '0;
    logic [15:0] buf_start = 16'h1000;
    logic [15:0] buf_end = 16'h101F;
    logic        mod_en = 1'b0;
    logic        bitrev_wr_active = 1'b0;
    logic        is_write = 1'b0;
    logic        out_valid;
    logic [15:0] ea_out;
    logic [15:0] wb_data;
    logic        wb_en;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        string       tag;
        logic [15:0] ea;
        logic [15:0] wb;
        logic        wben;
    } exp_t;

    exp_t exp_q[$];

    modaddr_unit i_modaddr_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ptr_in(ptr_in),
        .modifier(modifier), .addr_mode(addr_mode), .buf_start(buf_start),
        .buf_end(buf_end), .mod_en(mod_en), .bitrev_wr_active(bitrev_wr_active),
        .is_write(is_write), .out_valid(out_valid), .ea_out(ea_out),
        .wb_data(wb_data), .wb_en(wb_en)
    );

    always #4 clk = ~clk;

    task automatic send(input string tag, input logic [15:0] p, input logic [15:0] m,
                        input logic [1:0] md, input logic en, input logic brev,
                        input logic wr, input logic [15:0] e_ea,
                        input logic [15:0] e_wb, input logic e_wben);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; ptr_in = p; modifier = m; addr_mode = md;
        mod_en = en; bitrev_wr_active = brev; is_write = wr;
        e.tag = tag; e.ea = e_ea; e.wb = e_wb; e.wben = e_wben;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each produced result against the scoreboard head.
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R9: unexpected result ea=%h expected no result", ea_out);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (ea_out !== e.ea) begin
                        fails++;
                        $display("FAIL %s: ea_out=%h expected %h", e.tag, ea_out, e.ea);
                    end
                    checks++;
                    if (wb_en !== e.wben) begin
                        fails++;
                        $display("FAIL %s: wb_en=%b expected %b", e.tag, wb_en, e.wben);
                    end
                    if (e.wben) begin
                        checks++;
                        if (wb_data !== e.wb) begin
                            fails++;
                            $display("FAIL %s: wb_data=%h expected %h", e.tag, wb_data, e.wb);
                        end
                    end
                end
            end else begin
                checks++;
                if (wb_en !== 1'b0) begin
                    fails++;
                    $display("FAIL R9: idle wb_en=%b expected 0", wb_en);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        // R9 reset state
        checks++;
        if (out_valid !== 1'b0 || wb_en !== 1'b0 || ea_out !== 16'h0 || wb_data !== 16'h0) begin
            fails++;
            $display("FAIL R9: reset outputs v=%b s=%b ea=%h wb=%h expected 0 0 0000 0000",
                     out_valid, wb_en, ea_out, wb_data);
        end

        send("R4", 16'h1010, 16'h0002, 2'd0, 1, 0, 0, 16'h1012, 16'h1012, 1);
        send("R1", 16'h101D, 16'h0002, 2'd0, 1, 0, 0, 16'h101F, 16'h101F, 1);
        send("R1", 16'h101E, 16'h0002, 2'd0, 1, 0, 0, 16'h1000, 16'h1000, 1);
        send("R3", 16'h1018, 16'h000C, 2'd0, 1, 0, 0, 16'h1004, 16'h1004, 1);
        idle();
        send("R2", 16'h1002, 16'hFFFE, 2'd0, 1, 0, 0, 16'h1000, 16'h1000, 1);
        send("R2", 16'h1000, 16'hFFFE, 2'd0, 1, 0, 0, 16'h101E, 16'h101E, 1);
        send("R3", 16'h1004, 16'hFFF6, 2'd0, 1, 0, 0, 16'h101A, 16'h101A, 1);
        send("R3", 16'h1000, 16'h0020, 2'd0, 1, 0, 0, 16'h1000, 16'h1000, 1);
        send("R5", 16'h101E, 16'h0004, 2'd1, 1, 0, 1, 16'h101E, 16'h1002, 1);
        send("R5", 16'h1000, 16'hFFFC, 2'd1, 1, 0, 0, 16'h1000, 16'h101C, 1);
        send("R6", 16'h101E, 16'h0006, 2'd2, 1, 0, 0, 16'h1004, 16'h0000, 0);
        send("R6", 16'h1002, 16'hFFFA, 2'd3, 1, 0, 0, 16'h101C, 16'h0000, 0);
        idle();
        send("R7", 16'h101E, 16'h0002, 2'd0, 1, 1, 1, 16'h1020, 16'h1020, 1);
        send("R7", 16'h101E, 16'h0002, 2'd0, 1, 1, 0, 16'h1000, 16'h1000, 1);
        send("R7", 16'h1000, 16'hFFFE, 2'd2, 1, 1, 1, 16'h0FFE, 16'h0000, 0);
        send("R8", 16'h101E, 16'h0002, 2'd0, 0, 0, 0, 16'h1020, 16'h1020, 1);
        send("R8", 16'h1000, 16'hFFFE, 2'd1, 0, 0, 0, 16'h1000, 16'h0FFE, 1);
        send("R8", 16'h101E, 16'h0004, 2'd2, 0, 0, 0, 16'h1022, 16'h0000, 0);
        idle();
        idle();
        idle();

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R9: %0d results missing, expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule